// File: doc/BRIEF.md
# Serial Even-Parity Inserter

This block takes a serial bit stream, one bit per accepted transfer, and groups it into frames of four slots. The first three slots of a frame carry message bits. The block passes a 0 to the output in those slots. In the fourth slot it emits a parity bit instead. The parity bit is chosen so that the three message bits plus the parity bit hold an even number of ones. Whatever the input carries during that fourth slot is discarded.

The state is a two-bit slot position and a one-bit running parity flag. Both stay unchanged unless a transfer happens.

Transfers follow valid/ready rules on both sides, and the block adds no buffering. A slot completes only in a cycle where `in_valid_i` and `out_ready_i` are both high. `in_ready_o` follows `out_ready_i` in the same cycle, so downstream back-pressure reaches the source at once. `out_valid_o` follows `in_valid_i`, so the parity slot also needs an input beat, whose value is ignored. A synchronous reset moves the block back to the start of a frame.

Top module: `serial_parity_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, the slot position returns to the first message slot and the parity flag clears. After reset, `out_data_o` is 0.
- R2: In each of the three message slots, `out_data_o` is 0.
- R3: In the fourth (parity) slot, `out_data_o` is the XOR of the three message bits accepted in that frame. A frame with an odd number of ones gives 1, and a frame with an even number gives 0.
- R4: The value on `in_data_i` during an accepted parity-slot transfer has no effect on any later output.
- R5: After the parity slot is accepted, the parity flag restarts at 0 for the next message. The slot sequence is 0,1,2,3,0, and so on.
- R6: In a cycle without a transfer (`in_valid_i` low or `out_ready_i` low), neither the slot position nor the parity flag changes, and any input data in that cycle is ignored.
- R7: `in_ready_o` equals `out_ready_i`, and `out_valid_o` equals `in_valid_i`, in the same cycle.
- R8: Across every frame, the four output bits together with the three message bits carry an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Source offers a bit |
| in_ready_o | output | 1 | Block can take a bit this cycle |
| in_data_i | input | 1 | Serial input bit |
| out_valid_o | output | 1 | Output bit is offered |
| out_ready_i | input | 1 | Sink accepts the output bit |
| out_data_o | output | 1 | Serial output: 0 in message slots, parity in the fourth slot |

## Verification
The bound checker checks several rules on every clock: the slot advance and wrap order, the parity flag update on message beats, the clear after the parity beat, the hold during stalls, the zero output in message slots, and the state after reset. Only the directed scenarios can show that the bit emitted really is the even parity of real message patterns. The same holds for a parity-slot input being discarded, and for a reset in the middle of a frame realigning the frame boundary. Those checks depend on the exact history of inputs over whole frames.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  parameter int unsigned PG_MSG_BITS = 3;
  localparam int unsigned PG_FRAME   = PG_MSG_BITS + 1;
  localparam int unsigned PG_SLOT_W  = $clog2(PG_FRAME);
  typedef logic [PG_SLOT_W-1:0] slot_t;
  localparam slot_t PG_LAST_SLOT = slot_t'(PG_MSG_BITS);
endpackage

// File: rtl/pgen_slot_ctr.sv
module pgen_slot_ctr
  import pgen_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  step_i,
  output slot_t slot_o,
  output logic  last_o
);
  slot_t slot_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_q <= '0;
    end else if (step_i) begin
      if (slot_q == PG_LAST_SLOT) slot_q <= '0;
      else                        slot_q <= slot_q + slot_t'(1);
    end
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == PG_LAST_SLOT);
endmodule

// File: rtl/pgen_parity_acc.sv
module pgen_parity_acc (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  logic last_i,
  input  logic bit_i,
  output logic par_o
);
  logic par_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      par_q <= 1'b0;
    end else if (step_i) begin
      // parity beat closes the frame; its input bit is dropped
      if (last_i) par_q <= 1'b0;
      else        par_q <= par_q ^ bit_i;
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/pgen_out_sel.sv
module pgen_out_sel (
  input  logic last_i,
  input  logic par_i,
  output logic bit_o
);
  always_comb begin
    bit_o = 1'b0;
    if (last_i) bit_o = par_i;
  end
endmodule

// File: rtl/serial_parity_gen.sv
module serial_parity_gen
  import pgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  input  logic in_data_i,
  output logic out_valid_o,
  input  logic out_ready_i,
  output logic out_data_o
);
  logic  step;
  logic  last;
  logic  par;
  slot_t slot_q;

  // a beat moves only when source and sink agree
  assign step        = in_valid_i & out_ready_i;
  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i;

  pgen_slot_ctr u_slot (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step),
    .slot_o (slot_q),
    .last_o (last)
  );

  pgen_parity_acc u_par (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step),
    .last_i (last),
    .bit_i  (in_data_i),
    .par_o  (par)
  );

  pgen_out_sel u_sel (
    .last_i (last),
    .par_i  (par),
    .bit_o  (out_data_o)
  );
endmodule

// File: rtl/serial_parity_gen_chk.sv
module serial_parity_gen_chk
  import pgen_pkg::*;
(
  input logic  clk_i,
  input logic  rst_i,
  input logic  in_valid_i,
  input logic  out_ready_i,
  input logic  in_data_i,
  input logic  out_data_o,
  input slot_t slot_q,
  input logic  par
);
  logic beat;
  assign beat = in_valid_i & out_ready_i;

  // R1: reset lands on slot 0 with a clear flag
  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (slot_q == '0 && par == 1'b0 && out_data_o == 1'b0));

  // R2: message slots keep the line low
  p_quiet_msg_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q != PG_LAST_SLOT) |-> (out_data_o == 1'b0));

  // R3: flag folds in each message bit
  p_fold_bit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (beat && slot_q != PG_LAST_SLOT) |=> (par == ($past(par) ^ $past(in_data_i))));

  // R5: slot order and wrap
  p_slot_order_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (beat && slot_q != PG_LAST_SLOT) |=> (slot_q == $past(slot_q) + slot_t'(1)));

  // R4 / R5: parity beat clears flag and wraps regardless of input
  p_frame_close_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (beat && slot_q == PG_LAST_SLOT) |=> (slot_q == '0 && par == 1'b0));

  // R6: stalls hold all state
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !beat |=> ($stable(slot_q) && $stable(par)));
endmodule

bind serial_parity_gen serial_parity_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .in_valid_i  (in_valid_i),
  .out_ready_i (out_ready_i),
  .in_data_i   (in_data_i),
  .out_data_o  (out_data_o),
  .slot_q      (slot_q),
  .par         (par)
);

// File: tb/serial_parity_gen_tb_top.sv
module serial_parity_gen_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_data, out_valid, out_ready, out_data;
  int   n_run  = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  serial_parity_gen dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one accepted beat; output sampled mid-cycle before the edge
  task automatic beat(input logic b, input logic exp_out, input string tag);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    in_data   = b;
    #1;
    chk(out_data, exp_out, tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame(input logic [2:0] m, input logic junk, input string tag);
    logic p;
    int   ones;
    p = ^m;
    beat(m[0], 1'b0, {tag, " R2 slot0"});
    beat(m[1], 1'b0, {tag, " R2 slot1"});
    beat(m[2], 1'b0, {tag, " R2 slot2"});
    beat(junk, p,    {tag, " R3 parity"});
    ones = $countones(m) + int'(p);
    chk(ones[0], 1'b0, {tag, " R8 even total"});
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_data, 1'b0, "R1 out after reset");
    // three beats of zeros then parity 0 proves slot 0 start
    frame(3'b000, 1'b0, "R1 aligned");
  endtask

  task automatic t_patterns();
    for (int v = 0; v < 8; v++) frame(v[2:0], 1'b0, "R3 pattern");
  endtask

  task automatic t_ignore();
    frame(3'b000, 1'b1, "R4 junk high");
    frame(3'b100, 1'b1, "R4 next frame");
    frame(3'b000, 1'b0, "R5 fresh frame");
  endtask

  task automatic t_stall();
    beat(1'b1, 1'b0, "R6 pre");
    // valid low with data high
    in_valid = 1'b0; out_ready = 1'b1; in_data = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_data, 1'b0, "R6 idle hold");
    // sink stalls while source offers
    in_valid = 1'b1; out_ready = 1'b0; in_data = 1'b1;
    #1;
    chk(in_ready, 1'b0, "R7 ready follows sink");
    chk(out_valid, 1'b1, "R7 valid follows source");
    repeat (3) @(negedge clk);
    chk(out_data, 1'b0, "R6 backpressure hold");
    beat(1'b1, 1'b0, "R6 slot1");
    beat(1'b0, 1'b0, "R6 slot2");
    beat(1'b0, 1'b0, "R6 parity even");
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(in_ready, 1'b1, "R7 ready high");
    chk(out_valid, 1'b0, "R7 valid low");
    @(negedge clk);
  endtask

  task automatic t_mid_reset();
    beat(1'b1, 1'b0, "R1 mid a");
    beat(1'b1, 1'b0, "R1 mid b");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    frame(3'b100, 1'b0, "R1 realign");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_ignore();
    t_stall();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule